// File: doc/BRIEF.md
# Buck PWM Output Stage Controller

This block produces the two control outputs of a synchronous buck stage: a high-side (main switch) enable and a low-side (synchronous rectifier) enable. Each switching period opens with a one-clock cycle-start tick. On that tick the block latches an on-time length equal to the smallest of three values: the requested duty count, the soft-start cap, and the period length minus a fixed off-time reserve. It then holds the main output high for that many clock cycles.

An over-current flag cuts the pulse short. This flag is not looked at during a short blanking window at the beginning of each pulse. Once it trips, the main output stays off until the next tick. When the enable is low, both outputs are driven low. This differs from the normal off state, in which the synchronous output is high. The analog comparators, the ramp generation and the gate drivers sit outside this block. The block sees only their digital results.

Top module: `buck_pwm_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released with enable low, both outputs are low.
- R2: When enable is high and the tick is sampled high at a clock edge, the main output is high for exactly N consecutive cycles, starting with the cycle after that edge. N = min(duty request, soft-start cap, period length − MIN_OFF_CYC).
- R3: While enabled, the synchronous output is the logical inverse of the main output in every cycle.
- R4: In every period the main output is low for at least MIN_OFF_CYC cycles, so a duty request at or above the period length gives N = period length − MIN_OFF_CYC (default MIN_OFF_CYC = 3).
- R5: A soft-start cap below the duty request limits N to the cap value.
- R6: If N is zero (zero duty request or zero cap), the main output does not go high in that period.
- R7: An over-current flag sampled high at the edge that closes pulse cycle j (counted from 1), where j > BLANK_CYC, ends the pulse after cycle j. The main output then stays low for the rest of the period, even after the flag drops.
- R8: An over-current flag that is high only during pulse cycles 1 to BLANK_CYC has no effect on the pulse length (default BLANK_CYC = 2).
- R9: If enable is sampled low, both outputs are low from the next cycle on. After enable returns high, the main output stays low and the synchronous output is high until a tick starts a new pulse.
- R10: Changes to the duty request, the soft-start cap or the period length between ticks do not change the pulse already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable; low forces both outputs low |
| cyc_tick | input | 1 | One-cycle pulse marking the start of a switching period |
| cyc_len | input | CNT_W | Switching period length in clock cycles |
| duty_req | input | CNT_W | Requested on time in clock cycles |
| ss_cap | input | CNT_W | Soft-start on-time cap in clock cycles |
| ocp_in | input | 1 | Over-current flag from the current-sense comparator |
| hs_on | output | 1 | Main (high-side) switch enable |
| ls_on | output | 1 | Synchronous (low-side) switch enable |

## Verification
The assertions assume two things about the inputs. First, `cyc_len` matches the real spacing between ticks. Second, the tick lasts exactly one clock. Without these, the off-time reserve does not describe a real period. The stimulus meets both conditions. It drives each tick once, then waits exactly `cyc_len` cycles before the next one. Inputs are changed only on falling edges. Duty, cap and period values are drawn at random, while the over-current position is either random or placed by hand at the blanking boundary.

// File: rtl/buck_pwm_pkg.sv
`timescale 1ns/1ps
package buck_pwm_pkg;

    // Phase of the main-switch pulse within one switching period
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no pulse: period finished or nothing requested
        PH_ON   = 2'd1,   // main switch conducting
        PH_TRIP = 2'd2    // pulse cut by over-current, waiting for next tick
    } phase_e;

    // Captured per-period pulse plan
    typedef struct packed {
        logic [15:0] len;   // upper bits unused for narrow counters
        logic        live;
    } plan_t;

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/buck_limit_sel.sv
`timescale 1ns/1ps
module buck_limit_sel #(
    parameter int CNT_W       = 8,
    parameter int MIN_OFF_CYC = 3
) (
    input  logic [CNT_W-1:0] cyc_len,
    input  logic [CNT_W-1:0] duty_req,
    input  logic [CNT_W-1:0] ss_cap,
    output logic [CNT_W-1:0] on_len
);
    import buck_pwm_pkg::*;

    localparam logic [CNT_W-1:0] MOFF_W = CNT_W'(MIN_OFF_CYC);

    logic [CNT_W-1:0] max_on;
    int unsigned      dmin;

    // Longest pulse that still leaves the off-time reserve
    assign max_on = (cyc_len > MOFF_W) ? (cyc_len - MOFF_W) : '0;

    always_comb begin
        dmin   = umin(32'(duty_req), 32'(ss_cap));
        on_len = CNT_W'(umin(dmin, 32'(max_on)));
    end

    // R4: the chosen length never eats into the off-time reserve
    always_comb begin
        a_r4_on_le_max: assert (on_len <= max_on || cyc_len <= MOFF_W);
    end

endmodule

// File: rtl/buck_pulse_timer.sv
`timescale 1ns/1ps
module buck_pulse_timer #(
    parameter int CNT_W     = 8,
    parameter int BLANK_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] on_len,
    input  logic             ocp,
    output logic             drive_on
);
    import buck_pwm_pkg::*;

    localparam logic [CNT_W-1:0] BLANK_W = CNT_W'(BLANK_CYC);

    phase_e           ph;
    logic [CNT_W-1:0] cnt;     // pulse cycle index, 1 in the first on cycle
    logic [CNT_W-1:0] len_q;   // length captured at the tick
    logic             ocp_ok;  // blanking window has passed

    assign ocp_ok   = (cnt > BLANK_W);
    assign drive_on = (ph == PH_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            len_q <= '0;
        end else if (!en) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else if (tick) begin
            len_q <= on_len;
            cnt   <= CNT_W'(1);
            ph    <= (on_len != '0) ? PH_ON : PH_IDLE;
        end else begin
            case (ph)
                PH_ON: begin
                    if (ocp && ocp_ok)
                        ph <= PH_TRIP;
                    else if (cnt >= len_q)
                        ph <= PH_IDLE;
                    else
                        cnt <= cnt + CNT_W'(1);
                end
                default: ph <= ph;   // idle and tripped wait for the tick
            endcase
        end
    end

    // R2: a running pulse never outlasts its captured length
    a_r2_within_len: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ON) |-> (cnt != '0 && cnt <= len_q));

    // R8: inside the blanking window a pulse that is not yet due to end keeps running
    a_r8_blank_holds: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ON && en && !tick && cnt <= BLANK_W && cnt < len_q) |=> (ph == PH_ON));

    // R7: a tripped pulse does not restart before the next tick
    a_r7_trip_latched: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_TRIP && !tick) |=> (ph != PH_ON));

    // R6: an empty plan gives no pulse
    a_r6_zero_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (en && tick && on_len == '0) |=> !drive_on);

endmodule

// File: rtl/buck_out_stage.sv
`timescale 1ns/1ps
module buck_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic drive_on,
    output logic hs_on,
    output logic ls_on
);
    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= en;
    end

    assign hs_on = drive_on;
    assign ls_on = run_q & ~drive_on;

    // R9: a disable sampled at an edge leaves both switches off afterwards
    a_r9_disable_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!hs_on && !ls_on));

    // R3: never both switches on
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        hs_on |-> !ls_on);

endmodule

// File: rtl/buck_pwm_ctrl.sv
`timescale 1ns/1ps
module buck_pwm_ctrl #(
    parameter int CNT_W       = 8,
    parameter int MIN_OFF_CYC = 3,
    parameter int BLANK_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cyc_tick,
    input  logic [CNT_W-1:0] cyc_len,
    input  logic [CNT_W-1:0] duty_req,
    input  logic [CNT_W-1:0] ss_cap,
    input  logic             ocp_in,
    output logic             hs_on,
    output logic             ls_on
);
    logic [CNT_W-1:0] on_len;
    logic             drive_on;

    buck_limit_sel #(.CNT_W(CNT_W), .MIN_OFF_CYC(MIN_OFF_CYC)) lim_i (
        .cyc_len  (cyc_len),
        .duty_req (duty_req),
        .ss_cap   (ss_cap),
        .on_len   (on_len)
    );

    buck_pulse_timer #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (cyc_tick),
        .on_len   (on_len),
        .ocp      (ocp_in),
        .drive_on (drive_on)
    );

    buck_out_stage out_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .drive_on (drive_on),
        .hs_on    (hs_on),
        .ls_on    (ls_on)
    );

    // R2: a tick with a non-empty plan raises the main output next cycle
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (en && cyc_tick && on_len != '0) |=> hs_on);

endmodule

// File: tb/buck_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module buck_pwm_ctrl_tb_top;
    localparam int W     = 8;
    localparam int MOFF  = 3;
    localparam int BLANK = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic cyc_tick = 1'b0;
    logic [W-1:0] cyc_len = '0;
    logic [W-1:0] duty_req = '0;
    logic [W-1:0] ss_cap = '0;
    logic ocp_in = 1'b0;
    logic hs_on, ls_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    buck_pwm_ctrl #(.CNT_W(W), .MIN_OFF_CYC(MOFF), .BLANK_CYC(BLANK)) dut_i (
        .clk(clk), .rst(rst), .en(en), .cyc_tick(cyc_tick), .cyc_len(cyc_len),
        .duty_req(duty_req), .ss_cap(ss_cap), .ocp_in(ocp_in),
        .hs_on(hs_on), .ls_on(ls_on)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Expected pulse length from the requirements
    function automatic int exp_len(input int L, input int d, input int s, input int oc);
        int n;
        n = imin(imin(d, s), (L > MOFF) ? L - MOFF : 0);
        if (oc > BLANK && oc < n) n = oc;
        return n;
    endfunction

    // One switching period; called right after a falling edge
    task automatic run_cycle(input int L, input int d, input int s, input int oc,
                             input bit scramble, input string tag);
        int n, hi, lo, mis;
        n = exp_len(L, d, s, oc);
        hi = 0; lo = 0; mis = 0;
        cyc_len = W'(L); duty_req = W'(d); ss_cap = W'(s);
        cyc_tick = 1'b1; ocp_in = 1'b0;
        for (int i = 1; i <= L; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (hs_on) hi++;
            if (ls_on) lo++;
            if (ls_on == hs_on) mis++;
            if (hs_on != (i <= n)) mis++;
            cyc_tick = 1'b0;
            ocp_in = (i == oc);
            if (scramble) begin   // R10: mid-period changes must not matter
                duty_req = W'($urandom_range(0, 60));
                ss_cap   = W'($urandom_range(0, 60));
                cyc_len  = W'($urandom_range(4, 60));
            end
        end
        ocp_in = 1'b0;
        cyc_len = W'(L);
        check(hi == n && mis == 0, tag, hi, n);
        check(mis == 0, "R3 complement", mis, 0);
        check(lo == L - n && lo >= MOFF, "R4 off time", lo, L - n);
    endtask

    initial begin
        void'($urandom(32'd9173));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!hs_on && !ls_on, "R1 in reset", {hs_on, ls_on}, 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!hs_on && !ls_on, "R1 after reset", {hs_on, ls_on}, 0);
        en = 1'b1;
        @(posedge clk); @(negedge clk);

        run_cycle(20, 8, 30, 0, 1'b0, "R2 plain");
        run_cycle(20, 200, 200, 0, 1'b0, "R4 duty clamp");
        run_cycle(25, 15, 4, 0, 1'b0, "R5 soft-start cap");
        run_cycle(20, 0, 30, 0, 1'b0, "R6 zero duty");
        run_cycle(20, 12, 0, 0, 1'b0, "R6 zero cap");
        run_cycle(20, 10, 30, 5, 1'b0, "R7 over-current cut");
        run_cycle(20, 10, 30, BLANK + 1, 1'b0, "R7 first unblanked cycle");
        run_cycle(20, 10, 30, 1, 1'b0, "R8 blank first cycle");
        run_cycle(20, 10, 30, BLANK, 1'b0, "R8 blank last cycle");
        run_cycle(30, 12, 14, 0, 1'b1, "R10 mid-period change");
        run_cycle(4, 200, 200, 0, 1'b0, "R4 shortest period");

        // R9: disable mid-pulse, then re-enable without a tick
        cyc_len = 8'd30; duty_req = 8'd20; ss_cap = 8'd20; cyc_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        cyc_tick = 1'b0;
        @(posedge clk); @(negedge clk);
        check(hs_on && !ls_on, "R9 pulse before disable", {hs_on, ls_on}, 2);
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!hs_on && !ls_on, "R9 disable next cycle", {hs_on, ls_on}, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!hs_on && !ls_on, "R9 stays disabled", {hs_on, ls_on}, 0);
        en = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!hs_on && ls_on, "R9 re-enable no pulse", {hs_on, ls_on}, 1);
        @(posedge clk); @(negedge clk);

        // Random periods
        for (int k = 0; k < 250; k++) begin
            int L, d, s, oc;
            L  = $urandom_range(4, 40);
            d  = $urandom_range(0, L + 4);
            s  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, L) : 255;
            oc = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, L);
            run_cycle(L, d, s, oc, k[0], "R2 random period");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule